// File: doc/BRIEF.md
# Event Road Capture and Sparsifier

This block sits between a pattern-matching array and a one-wire serial link toward track fitting. While the hit words of an event stream in, the array raises one flag per road that matched. An end-of-event marker on the same input stream makes the block copy the whole flag vector into a private snapshot in one clock. In the following cycle it pulses a clear strobe, so the array can start on the next event at once.

The snapshot is then scanned, lowest road first. Each set flag becomes one word holding that road's address. After the last road, a trailer word closes the record. Words pass through a small FIFO to a serializer, which sends each word behind a start bit. Scanning and sending of one event overlap with the collection of the next. A second end-of-event marker that arrives during a scan is held off until the scan has finished.

The capture/scan machine has three states:
- IDLE: waiting for a marker.
- SCAN: emitting road words.
- TRAILER: pushing the closing word.

Its transitions are:
- marker accepted: IDLE to SCAN.
- snapshot exhausted: SCAN to TRAILER.
- trailer pushed: TRAILER to IDLE.

The serializer has three states:
- LINE_IDLE
- START_BIT
- SHIFT

Its transitions are:
- word popped: LINE_IDLE to START_BIT.
- start sent: START_BIT to SHIFT.
- last bit sent: SHIFT to LINE_IDLE.

Top module: `road_snap_serializer`

## Requirements
- R1: An end-of-event marker (`ev_valid`=1 and `ev_is_eoe`=1) that is accepted copies all of `match_vec` into the snapshot at that clock edge. Changes on `match_vec` after that edge do not alter the words sent for that event.
- R2: `array_clear` is high for exactly one cycle, in the cycle right after the accepting edge, and is low at all other times.
- R3: One word is produced for each set snapshot bit, in ascending road index order, with at most one word per clock. A road word has bit 6 = 0 and bits 5:0 = the road index.
- R4: After the last road word of an event, a trailer word is emitted with bit 6 = 1 and bits 5:0 = 0. This trailer is sent even when no road matched.
- R5: While a snapshot is being scanned or its trailer is pending, an end-of-event marker on the input sees `busy`=1 and `ev_ready`=0, and no capture is taken. Non-marker hit words always see `ev_ready`=1. The held marker is accepted once the machine is back in IDLE.
- R6: The FIFO holds 16 words. The scanner pushes nothing while the FIFO is full, and no word is lost or reordered under backpressure.
- R7: The serial line idles at 0. Each word is sent as one cycle of 1 (start bit) followed by its 7 bits, bit 6 first, one bit per cycle.
- R8: After reset, `array_clear`=0, `busy`=0, `ev_ready`=1 and `ser_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Input stream word present |
| ev_is_eoe | input | 1 | Present word is the end-of-event marker |
| ev_ready | output | 1 | Input word accepted this cycle |
| busy | output | 1 | Marker presented while previous scan still running |
| match_vec | input | 64 | Per-road match flags from the pattern array |
| array_clear | output | 1 | One-cycle release strobe to the pattern array |
| ser_out | output | 1 | Serial word stream, start bit then MSB first |

## Verification
The embedded assertions check four things on every cycle:
- the clear strobe never lasts two cycles, and never follows a cycle spent scanning;
- the FIFO is never pushed when full or popped when empty;
- a trailer is pushed only once the snapshot is empty;
- a start bit is always followed by the shift state.

Several behaviours can only be shown by the bench's scenarios, because they depend on the whole event history:
- that a snapshot ignores later changes on the match inputs;
- the ascending order and exact content of the decoded serial words;
- the trailer for an empty event;
- stalling of a back-to-back marker;
- lossless delivery when all 64 roads match and the FIFO fills.

// File: rtl/rsnap_pkg.sv
package rsnap_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SCAN    = 2'd1,
        S_TRAILER = 2'd2
    } scan_state_t;

    typedef enum logic [1:0] {
        L_IDLE  = 2'd0,
        L_START = 2'd1,
        L_SHIFT = 2'd2
    } line_state_t;
endpackage

// File: rtl/rsnap_scan.sv
module rsnap_scan
    import rsnap_pkg::*;
#(
    parameter int N_ROADS = 64,
    parameter int ADDR_W  = $clog2(N_ROADS),
    parameter int WORD_W  = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               ev_is_eoe,
    output logic               ev_ready,
    output logic               busy,
    input  logic [N_ROADS-1:0] match_vec,
    output logic               array_clear,
    input  logic               fifo_full,
    output logic               push,
    output logic [WORD_W-1:0]  push_word
);
    scan_state_t        state, nxt;
    logic [N_ROADS-1:0] snap;
    logic [ADDR_W-1:0]  low_idx;
    logic               take, drop_low, clr_q;

    // Lowest set bit of the snapshot
    always_comb begin
        low_idx = '0;
        for (int i = N_ROADS - 1; i >= 0; i--) begin
            if (snap[i]) low_idx = ADDR_W'(i);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state and outputs
    always_comb begin
        nxt       = state;
        take      = 1'b0;
        push      = 1'b0;
        push_word = '0;
        drop_low  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (ev_valid && ev_is_eoe) begin
                    take = 1'b1;
                    nxt  = S_SCAN;
                end
            end
            S_SCAN: begin
                if (snap == '0) begin
                    nxt = S_TRAILER;
                end else if (!fifo_full) begin
                    push      = 1'b1;
                    push_word = {1'b0, low_idx};
                    drop_low  = 1'b1;
                end
            end
            S_TRAILER: begin
                if (!fifo_full) begin
                    push      = 1'b1;
                    push_word = {1'b1, {ADDR_W{1'b0}}};
                    nxt       = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    assign ev_ready    = !(ev_is_eoe && state != S_IDLE);
    assign busy        = ev_valid && ev_is_eoe && (state != S_IDLE);
    assign array_clear = clr_q;

    // Snapshot and release strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap  <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= take;
            if (take)          snap          <= match_vec;
            else if (drop_low) snap[low_idx] <= 1'b0;
        end
    end

    assert_clear_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        array_clear |=> !array_clear);
    assert_no_recapture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> !array_clear);
    assert_trailer_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_word[WORD_W-1]) |-> (snap == '0));
    assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);
endmodule

// File: rtl/rsnap_fifo.sv
module rsnap_fifo #(
    parameter int WIDTH = 7,
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;

    assign full    = (count == (PTR_W+1)'(DEPTH));
    assign empty   = (count == '0);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == (PTR_W+1)'(DEPTH)) |-> !push);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !pop);
endmodule

// File: rtl/rsnap_ser.sv
module rsnap_ser
    import rsnap_pkg::*;
#(
    parameter int WORD_W = 7,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              empty,
    input  logic [WORD_W-1:0] rd_data,
    output logic              pop,
    output logic              ser_out
);
    line_state_t       state, nxt;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  left;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= L_IDLE;
        else        state <= nxt;
    end

    // Next state and outputs
    always_comb begin
        nxt     = state;
        pop     = 1'b0;
        ser_out = 1'b0;
        unique case (state)
            L_IDLE: begin
                if (!empty) begin
                    pop = 1'b1;
                    nxt = L_START;
                end
            end
            L_START: begin
                ser_out = 1'b1;
                nxt     = L_SHIFT;
            end
            L_SHIFT: begin
                ser_out = shreg[WORD_W-1];
                if (left == '0) nxt = L_IDLE;
            end
            default: nxt = L_IDLE;
        endcase
    end

    // Shift data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else begin
            unique case (state)
                L_IDLE:  if (!empty) shreg <= rd_data;
                L_START: left <= CNT_W'(WORD_W - 1);
                L_SHIFT: begin
                    shreg <= {shreg[WORD_W-2:0], 1'b0};
                    left  <= left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_start_then_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == L_START) |=> (state == L_SHIFT));
endmodule

// File: rtl/road_snap_serializer.sv
module road_snap_serializer #(
    parameter int N_ROADS    = 64,
    parameter int FIFO_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               ev_is_eoe,
    output logic               ev_ready,
    output logic               busy,
    input  logic [N_ROADS-1:0] match_vec,
    output logic               array_clear,
    output logic               ser_out
);
    localparam int ADDR_W = $clog2(N_ROADS);
    localparam int WORD_W = ADDR_W + 1;

    logic              push, pop, full, empty;
    logic [WORD_W-1:0] push_word, rd_data;

    rsnap_scan #(.N_ROADS(N_ROADS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_eoe(ev_is_eoe),
        .ev_ready(ev_ready), .busy(busy), .match_vec(match_vec),
        .array_clear(array_clear), .fifo_full(full), .push(push), .push_word(push_word)
    );

    rsnap_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_data(push_word), .pop(pop),
        .rd_data(rd_data), .full(full), .empty(empty)
    );

    rsnap_ser #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .empty(empty), .rd_data(rd_data),
        .pop(pop), .ser_out(ser_out)
    );
endmodule

// File: tb/road_snap_serializer_bench.sv
module road_snap_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_is_eoe = 1'b0;
    logic [63:0] match_vec = '0;
    logic        ev_ready, busy, array_clear, ser_out;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [6:0]  expq[$];
    int          n_rx = 0;
    int          n_exp = 0;

    always #4 clk = ~clk;   // 125 MHz

    road_snap_serializer u_road_snap_serializer (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_is_eoe(ev_is_eoe),
        .ev_ready(ev_ready), .busy(busy), .match_vec(match_vec),
        .array_clear(array_clear), .ser_out(ser_out)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-mon FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: present marker, wait for acceptance, queue expected words
    task automatic send_event(logic [63:0] v);
        @(negedge clk);
        match_vec = v;
        ev_valid  = 1'b1;
        ev_is_eoe = 1'b1;
        #1;
        while (!ev_ready) begin
            @(negedge clk);
            #1;
        end
        for (int i = 0; i < 64; i++) begin
            if (v[i]) begin
                expq.push_back({1'b0, 6'(i)});
                n_exp++;
            end
        end
        expq.push_back(7'h40);
        n_exp++;
        @(negedge clk);
        ev_valid  = 1'b0;
        ev_is_eoe = 1'b0;
        match_vec = ~v;                                   // R1: later change ignored
        check("R2 clear after capture", array_clear, 1'b1);
        @(negedge clk);
        check("R2 clear one cycle", array_clear, 1'b0);
    endtask

    // Monitor: decode serial frames and compare with scoreboard
    initial begin
        logic [6:0] w;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (ser_out) begin
                for (int b = 6; b >= 0; b--) begin
                    @(negedge clk);
                    w[b] = ser_out;
                end
                n_rx++;
                if (expq.size() == 0) begin
                    check("R3 unexpected word", w, 7'h7f);
                end else begin
                    logic [6:0] e;
                    e = expq.pop_front();
                    check(e[6] ? "R4 trailer word" : "R3/R7 road word", w, e);
                end
            end
        end
    end

    initial begin
        #1;
        check("R8 reset ser_out", ser_out, 1'b0);
        check("R8 reset clear", array_clear, 1'b0);
        check("R8 reset busy", busy, 1'b0);
        check("R8 reset ready", ev_ready, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // hit words pass freely
        @(negedge clk);
        ev_valid = 1'b1;
        #1;
        check("R5 hit ready", ev_ready, 1'b1);
        @(negedge clk);
        ev_valid = 1'b0;

        send_event(64'h0000_0000_0000_0020);             // R3 single road
        send_event(64'h0);                               // R4 empty event
        send_event(64'h8000_0000_0000_0001);             // R3 both ends
        send_event('1);                                  // R6 all roads, backpressure

        // R5: marker during scan is stalled
        @(negedge clk);
        ev_valid  = 1'b1;
        ev_is_eoe = 1'b1;
        #1;
        check("R5 busy while scanning", busy, 1'b1);
        check("R5 marker stalled", ev_ready, 1'b0);
        ev_is_eoe = 1'b0;
        #1;
        check("R5 hit not stalled", ev_ready, 1'b1);
        check("R2 no clear during stall", array_clear, 1'b0);
        ev_valid = 1'b0;
        send_event(64'h00F0_0000_1234_8000);             // R5 accepted after scan
        send_event(64'hA5A5_0000_0000_5A5A);             // R1 R3 mixed pattern

        // drain
        for (int t = 0; t < 5000 && (expq.size() != 0); t++) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R6 all words delivered", n_rx, n_exp);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R6 actual=timeout expected=drained");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule